// File: doc/BRIEF.md
# Bounded Wrap-Around Up/Down Counter

This block is a synchronous counter that steps by one in either direction and wraps between two programmable bounds instead of between zero and its full range. The two bounds share one data input. While counting is switched off, a qualifier marks the programming cycles. The first marked cycle writes the upper bound and the second marked cycle writes the lower bound. Both bounds stay in their own registers until they are written again.

When counting is switched on, the first enabled cycle seeds the count from the bound where the selected direction begins. Every later enabled cycle either steps the count or, when the count sits exactly on the bound the direction is heading towards, reloads the opposite bound. A single next-value selector picks one of five sources: hold, increment, decrement, load upper or load lower. When counting is switched off, the count freezes. The bounds can then be rewritten, or left as they are and reused.

Top module: `bwrap_counter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the count becomes 0, the lower bound becomes 0, the upper bound becomes all ones, and the programming pointer returns to its upper-bound step.
- R2: The bounds change only at an edge where `enable` is low and `load` is high. Every other edge leaves both bound outputs unchanged.
- R3: The first qualified programming edge writes `lim_in` into the upper bound. The next qualified edge writes `lim_in` into the lower bound. After that the pointer alternates again, starting with the upper bound.
- R4: Any edge with `enable` high returns the programming pointer to the upper-bound step, so a sequence left half done starts over with the upper bound.
- R5: Bounds that are not reprogrammed during an idle period are kept and used again by the next run.
- R6: While `enable` is low, the count holds its value.
- R7: At the first enabled edge after reset or after an idle period, the count loads the lower bound when `mode`=1 (up) and the upper bound when `mode`=0 (down).
- R8: On later enabled edges, the count goes up by one (modulo 2^W) when `mode`=1 and down by one when `mode`=0, unless R9 applies.
- R9: Counting up with the count equal to the upper bound, the next count is the lower bound. Counting down with the count equal to the lower bound, the next count is the upper bound.
- R10: A change of `mode` during a run takes effect at the next edge, starting from the current count.
- R11: When the lower bound is greater than the upper bound, the bounds are not corrected. The wrap happens only on an exact match, and the steps in between roll over modulo 2^W.
- R12: `load` and `lim_in` have no effect on either bound while `enable` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | High to count; low to idle and allow programming |
| mode | input | 1 | 1 = count up, 0 = count down |
| load | input | 1 | Marks a bound-programming cycle while idle |
| lim_in | input | W | Shared bound data |
| count | output | W | Current count |
| upper_lim | output | W | Stored upper bound |
| lower_lim | output | W | Stored lower bound |

## Verification
The bench goes after the wrap edges in both directions. A design that compares against the wrong bound, or reloads the same bound, would either run past the bound or stop on it. It also tests a half-finished programming sequence followed by a run. A pointer that does not restart would write the next value into the lower bound instead of the upper bound. Inverted bounds check that the count rolls through zero before matching, rather than being clamped. Load pulses during a run and direction flips in the middle of a run check that the bounds stay frozen and that the turn starts from the current count, not from a re-seed.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

  typedef enum logic [2:0] {
    SEL_HOLD  = 3'd0,
    SEL_INC   = 3'd1,
    SEL_DEC   = 3'd2,
    SEL_LD_HI = 3'd3,
    SEL_LD_LO = 3'd4
  } bwc_sel_t;

  typedef enum logic {
    PH_UPPER = 1'b0,
    PH_LOWER = 1'b1
  } bwc_phase_t;

endpackage

// File: rtl/bwc_limit_regs.sv
module bwc_limit_regs
  import bwc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         load,
  input  logic [W-1:0] lim_in,
  output logic [W-1:0] upper_q,
  output logic [W-1:0] lower_q,
  output bwc_phase_t   phase_q,
  output logic         wr_upper,
  output logic         wr_lower
);

  logic prog_cycle;

  assign prog_cycle = !enable && load;
  assign wr_upper   = prog_cycle && (phase_q == PH_UPPER);
  assign wr_lower   = prog_cycle && (phase_q == PH_LOWER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upper_q <= '1;
      lower_q <= '0;
      phase_q <= PH_UPPER;
    end else begin
      if (wr_upper) upper_q <= lim_in;
      if (wr_lower) lower_q <= lim_in;
      if (enable)          phase_q <= PH_UPPER;
      else if (prog_cycle) phase_q <= (phase_q == PH_UPPER) ? PH_LOWER : PH_UPPER;
    end
  end

endmodule

// File: rtl/bwc_next_sel.sv
module bwc_next_sel
  import bwc_pkg::*;
(
  input  logic     enable,
  input  logic     run_q,
  input  logic     mode,
  input  logic     at_upper,
  input  logic     at_lower,
  output bwc_sel_t sel
);

  always_comb begin
    if (!enable)     sel = SEL_HOLD;
    else if (!run_q) sel = mode ? SEL_LD_LO : SEL_LD_HI;
    else if (mode)   sel = at_upper ? SEL_LD_LO : SEL_INC;
    else             sel = at_lower ? SEL_LD_HI : SEL_DEC;
  end

endmodule

// File: rtl/bwc_count_reg.sv
module bwc_count_reg
  import bwc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  bwc_sel_t     sel,
  input  logic [W-1:0] upper,
  input  logic [W-1:0] lower,
  output logic [W-1:0] count_q,
  output logic         run_q
);

  function automatic logic [W-1:0] step_by_one(input logic [W-1:0] v, input logic up);
    return up ? W'(v + 1'b1) : W'(v - 1'b1);
  endfunction

  logic [W-1:0] count_d;

  always_comb begin
    unique case (sel)
      SEL_INC:   count_d = step_by_one(count_q, 1'b1);
      SEL_DEC:   count_d = step_by_one(count_q, 1'b0);
      SEL_LD_HI: count_d = upper;
      SEL_LD_LO: count_d = lower;
      default:   count_d = count_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      run_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      run_q   <= enable;
    end
  end

endmodule

// File: rtl/bwrap_counter.sv
module bwrap_counter
  import bwc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         mode,
  input  logic         load,
  input  logic [W-1:0] lim_in,
  output logic [W-1:0] count,
  output logic [W-1:0] upper_lim,
  output logic [W-1:0] lower_lim
);

  bwc_phase_t phase_q;
  bwc_sel_t   sel;
  logic       run_q;
  logic       wr_upper;
  logic       wr_lower;
  logic       at_upper;
  logic       at_lower;

  assign at_upper = (count == upper_lim);
  assign at_lower = (count == lower_lim);

  bwc_limit_regs #(.W(W)) u_limits (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .load     (load),
    .lim_in   (lim_in),
    .upper_q  (upper_lim),
    .lower_q  (lower_lim),
    .phase_q  (phase_q),
    .wr_upper (wr_upper),
    .wr_lower (wr_lower)
  );

  bwc_next_sel u_sel (
    .enable   (enable),
    .run_q    (run_q),
    .mode     (mode),
    .at_upper (at_upper),
    .at_lower (at_lower),
    .sel      (sel)
  );

  bwc_count_reg #(.W(W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .sel     (sel),
    .upper   (upper_lim),
    .lower   (lower_lim),
    .count_q (count),
    .run_q   (run_q)
  );

endmodule

// File: rtl/bwc_checker.sv
module bwc_checker
  import bwc_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enable,
  input logic         mode,
  input logic         load,
  input logic [W-1:0] lim_in,
  input logic [W-1:0] count,
  input logic [W-1:0] upper_lim,
  input logic [W-1:0] lower_lim,
  input logic         run_q,
  input bwc_phase_t   phase_q
);

  AST_LIMITS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (enable || !load) |=> ($stable(upper_lim) && $stable(lower_lim))); // R2

  AST_WRITE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && load && phase_q == PH_UPPER) |=> (upper_lim == $past(lim_in) && phase_q == PH_LOWER)); // R3

  AST_WRITE_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && load && phase_q == PH_LOWER) |=> (lower_lim == $past(lim_in) && phase_q == PH_UPPER)); // R3

  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> (phase_q == PH_UPPER)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(count)); // R6

  AST_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !run_q) |=> (count == ($past(mode) ? $past(lower_lim) : $past(upper_lim)))); // R7

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && run_q && mode && count != upper_lim) |=> (count == W'($past(count) + 1'b1))); // R8

  AST_DN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && run_q && !mode && count != lower_lim) |=> (count == W'($past(count) - 1'b1))); // R8

  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && run_q && mode && count == upper_lim) |=> (count == $past(lower_lim))); // R9

  AST_DN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && run_q && !mode && count == lower_lim) |=> (count == $past(upper_lim))); // R9

endmodule

bind bwrap_counter bwc_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .mode      (mode),
  .load      (load),
  .lim_in    (lim_in),
  .count     (count),
  .upper_lim (upper_lim),
  .lower_lim (lower_lim),
  .run_q     (run_q),
  .phase_q   (phase_q)
);

// File: tb/bwrap_counter_test.sv
module bwrap_counter_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enable = 1'b0;
  logic         mode = 1'b1;
  logic         load = 1'b0;
  logic [W-1:0] lim_in = '0;
  logic [W-1:0] count, upper_lim, lower_lim;

  int total = 0;
  int bad = 0;

  // reference state kept by the bench
  logic [W-1:0] e_cnt, e_hi, e_lo;
  logic         e_ph;   // 0: upper step next, 1: lower step next
  logic         e_run;

  always #2 clk = ~clk;

  bwrap_counter #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .load(load),
    .lim_in(lim_in), .count(count), .upper_lim(upper_lim), .lower_lim(lower_lim)
  );

  function automatic logic [W-1:0] ref_next(input logic [W-1:0] c, input logic [W-1:0] hi,
                                            input logic [W-1:0] lo, input logic en,
                                            input logic run, input logic up);
    if (!en) return c;
    if (!run) return up ? lo : hi;
    if (up) return (c == hi) ? lo : c + 1;
    return (c == lo) ? hi : c - 1;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp,
                       input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input string tag, input logic r, input logic en, input logic md,
                      input logic ld, input logic [W-1:0] d);
    @(negedge clk);
    rst_n = r; enable = en; mode = md; load = ld; lim_in = d;
    @(posedge clk);
    if (!r) begin
      e_cnt = '0; e_hi = '1; e_lo = '0; e_ph = 1'b0; e_run = 1'b0;
    end else begin
      e_cnt = ref_next(e_cnt, e_hi, e_lo, en, e_run, md);
      if (!en && ld) begin
        if (!e_ph) e_hi = d; else e_lo = d;
        e_ph = ~e_ph;
      end
      if (en) e_ph = 1'b0;
      e_run = en;
    end
    #1;
    check(tag, count, e_cnt, "count");
    check(tag, upper_lim, e_hi, "upper");
    check(tag, lower_lim, e_lo, "lower");
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    e_cnt = '0; e_hi = '1; e_lo = '0; e_ph = 1'b0; e_run = 1'b0;
    // R1 reset values
    step("R1", 0, 1, 1, 1, 8'h55);
    step("R1", 0, 0, 0, 0, 0);
    check("R1", count, 0, "reset count");
    check("R1", upper_lim, 8'hFF, "reset upper");
    check("R1", lower_lim, 0, "reset lower");
    // R3 program upper=20 then lower=10; idle cycle between is not qualified (R2)
    step("R3", 1, 0, 1, 1, 20);
    step("R2", 1, 0, 1, 0, 99);
    step("R3", 1, 0, 1, 1, 10);
    check("R3", upper_lim, 20, "upper programmed");
    check("R3", lower_lim, 10, "lower programmed");
    // R7 seed in up mode, R8 steps, R9 wrap upward
    for (int i = 0; i < 14; i++) step(i == 0 ? "R7" : (i == 11 ? "R9" : "R8"), 1, 1, 1, 0, 0);
    // R12 load during run ignored
    step("R12", 1, 1, 1, 1, 77);
    step("R12", 1, 1, 1, 1, 66);
    // R6 hold while idle
    for (int i = 0; i < 3; i++) step("R6", 1, 0, 0, 0, 5);
    // R5 reuse bounds, R7 down seed, R9 wrap downward
    for (int i = 0; i < 14; i++) step(i == 0 ? "R5" : (i == 11 ? "R9" : "R8"), 1, 1, 0, 0, 0);
    // R10 direction flip mid run
    step("R10", 1, 1, 1, 0, 0);
    step("R10", 1, 1, 0, 0, 0);
    step("R10", 1, 1, 1, 0, 0);
    // R4 half-finished programming restarts at upper
    step("R4", 1, 0, 1, 1, 30);
    step("R4", 1, 1, 1, 0, 0);
    step("R4", 1, 0, 1, 1, 40);
    check("R4", upper_lim, 40, "restarted write hits upper");
    check("R4", lower_lim, 10, "lower untouched");
    // R11 inverted bounds: upper=3, lower=250, count up rolls through zero
    step("R11", 1, 0, 1, 1, 250);
    step("R11", 1, 0, 1, 1, 3);
    step("R11", 1, 0, 1, 1, 250);
    for (int i = 0; i < 16; i++) step("R11", 1, 1, 1, 0, 0);
    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      logic [W-1:0] d;
      int sel;
      sel = $urandom_range(0, 9);
      d = W'($urandom_range(0, 255));
      step("RAND", ($urandom_range(0, 199) != 0), (sel > 3), ($urandom_range(0, 7) != 0),
           ($urandom_range(0, 1) == 1), d);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end

endmodule